// File: doc/BRIEF.md
# Two-Function Interrupt Merger

This block gathers interrupt causes from a network controller and a level request from a companion second function. It turns them into requests on two shared active-low host pins: a normal interrupt pin and a status-change pin. On the network side, a sticky cause register is gated by a per-bit mask register. A write-only command register holds a global enable and lets software inject an interrupt.

Each function has an option register and a status register. The option register sets the function's enable, its edge or level signalling, and which pin it drives. The status register sets the acknowledge policy. A global register shows which function is pending and can hide either one from the host.

Software reaches every register through a single-cycle register port. Writes take effect at the clock edge while `reg_we_i` is high. Reads are combinational from `reg_addr_i`.

Register map (address: content):
- 0: command, write only. Bit2 is loaded into the global network enable on every write. Bit3 = 1 forces an interrupt. Reads return 0.
- 1: cause. Writing 1 to a bit clears it.
- 2: mask.
- 3: global. Bit0 and bit2 are read only. Bit1 and bit3 are read/write.
- 4 and 6: network and second-function option registers. Bits 2, 5 and 6 are stored; the other bits read 0.
- 5 and 7: network and second-function status registers.

Top module: `irq_merge_top`

## Requirements
- R1: After reset, both pins are high (inactive), and every register reads 0.
- R2: A cause bit is set by a high level on the matching `net_evt_i` bit, and it stays set until software writes 1 to it at address 1. If an event and a clear of the same bit fall in the same cycle, the bit stays set. Bits 3 and 7 of `net_evt_i` are ignored, and cause bit 3 always reads 0.
- R3: A command write with bit3 = 1 sets cause bit 7 (forced interrupt).
- R4: The network function requests only when the global enable is 1 (command bit2, loaded on each command write) and at least one cause bit is set whose mask bit is also 1.
- R5: In the global register, bit0 reads network pending and bit2 reads second-function pending. A function is pending when its request flag is set and its option bit2 is 1. Bit1 = 1 hides the network function from both pins, and bit3 = 1 does the same for the second function; while hidden, the function still reads as pending.
- R6: A function whose option bit2 is 0 never drives either pin low.
- R7: With option bit6 = 1 (level mode), a function holds its pin low while it is pending and not hidden. The pin falls two edges after the request flag's source becomes true, and rises the same way after the source is removed.
- R8: With option bit6 = 0 (edge mode), each rising of a function's pending-and-unhidden state drives its pin low for exactly one clock cycle.
- R9: Option bit5 = 1 routes the function to `stschg_n_o` and bit5 = 0 routes it to `int_n_o`. The pin that is not selected stays high.
- R10: The status register's bit0 sets the acknowledge policy and bit1 reads the request flag. With bit0 = 1, the request flag stays set after its source goes away, until a status write with bit1 = 0 clears it. With bit0 = 0, the flag follows the source one cycle later.
- R11: The two functions share the pins. A pin is low whenever either function routed to it is asserting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| net_evt_i | input | 8 | Network cause events, one per cause bit |
| sf_irq_i | input | 1 | Second-function interrupt request, level |
| int_n_o | output | 1 | Normal interrupt pin, active low |
| stschg_n_o | output | 1 | Status-change pin, active low |

## Verification
Some properties are checked by assertions on every cycle. These are:
- cause bits never drop without a clear write;
- a forced write sets bit 7;
- a disabled or hidden function never asserts;
- an edge-mode function asserts for no more than one cycle at a time;
- an acknowledged request holds until the host clears it.

Other behaviour can only be shown by the bench's scenarios. This covers the exact latency from event to pin, the pin selected by the routing bit, the two functions sharing a pin, the global register's read value, and the clear-versus-event collision.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int NFUNC = 2;

  typedef enum logic [AW-1:0] {
    A_CMD      = 3'd0,
    A_CAUSE    = 3'd1,
    A_MASK     = 3'd2,
    A_GLOBAL   = 3'd3,
    A_NET_OPT  = 3'd4,
    A_NET_STAT = 3'd5,
    A_SF_OPT   = 3'd6,
    A_SF_STAT  = 3'd7
  } reg_addr_e;

  localparam int CMD_EN_BIT    = 2;
  localparam int CMD_FORCE_BIT = 3;
  localparam int CAUSE_FORCE   = 7;
  localparam int OPT_EN_BIT    = 2;
  localparam int OPT_ALT_BIT   = 5;
  localparam int OPT_LVL_BIT   = 6;
  localparam int ST_ACK_BIT    = 0;
  localparam int ST_REQ_BIT    = 1;

  localparam logic [DW-1:0] HW_CAUSE_MASK = 8'h77;
  localparam logic [DW-1:0] OPT_MASK      = 8'h64;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_merge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_we_i,
  input  logic          mask_we_i,
  input  logic          force_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mask_o,
  output logic          any_o
);
  logic [DW-1:0] cause_q, mask_q, clr_bits, set_bits;

  always_comb begin
    clr_bits = clr_we_i ? wdata_i : '0;
    set_bits = evt_i & HW_CAUSE_MASK;
    set_bits[CAUSE_FORCE] = force_i;
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_bits) | set_bits;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign any_o   = |(cause_q & mask_q);
endmodule

// File: rtl/irq_channel.sv
module irq_channel
  import irq_merge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_i,
  input  logic          opt_we_i,
  input  logic          stat_we_i,
  input  logic          hide_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] opt_o,
  output logic [DW-1:0] stat_o,
  output logic          pend_o,
  output logic          fire_o,
  output logic          route_o,
  output logic          level_o,
  output logic          en_o,
  output logic          ack_o,
  output logic          req_o
);
  logic [DW-1:0] opt_q;
  logic ack_q, req_q, active, active_q, fire_q, host_clr;

  assign host_clr = stat_we_i & ~wdata_i[ST_REQ_BIT];
  assign en_o     = opt_q[OPT_EN_BIT];
  assign level_o  = opt_q[OPT_LVL_BIT];
  assign route_o  = opt_q[OPT_ALT_BIT];
  assign pend_o   = req_q & en_o;
  assign active   = pend_o & ~hide_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q    <= '0;
      ack_q    <= 1'b0;
      req_q    <= 1'b0;
      active_q <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      if (opt_we_i)  opt_q <= wdata_i & OPT_MASK;
      if (stat_we_i) ack_q <= wdata_i[ST_ACK_BIT];
      if (ack_q) req_q <= src_i | (req_q & ~host_clr);
      else       req_q <= src_i;
      active_q <= active;
      fire_q   <= level_o ? active : (active & ~active_q);
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[ST_ACK_BIT] = ack_q;
    stat_o[ST_REQ_BIT] = req_q;
  end

  assign opt_o  = opt_q;
  assign fire_o = fire_q;
  assign ack_o  = ack_q;
  assign req_o  = req_q;
endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top
  import irq_merge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] net_evt_i,
  input  logic          sf_irq_i,
  output logic          int_n_o,
  output logic          stschg_n_o
);
  logic [DW-1:0] cause_w, mask_w;
  logic          net_any, glb_en_q, cmd_we;
  logic [NFUNC-1:0] gmask_q, src_w, fire_w, route_w, level_w, en_w, ack_w, req_w, pend_w;
  logic [NFUNC-1:0] opt_we_w, stat_we_w;
  logic [DW-1:0] opt_w  [NFUNC];
  logic [DW-1:0] stat_w [NFUNC];

  assign cmd_we = reg_we_i && (reg_addr_i == A_CMD);

  irq_cause_reg u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (net_evt_i),
    .clr_we_i  (reg_we_i && (reg_addr_i == A_CAUSE)),
    .mask_we_i (reg_we_i && (reg_addr_i == A_MASK)),
    .force_i   (cmd_we && reg_wdata_i[CMD_FORCE_BIT]),
    .wdata_i   (reg_wdata_i),
    .cause_o   (cause_w),
    .mask_o    (mask_w),
    .any_o     (net_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      gmask_q  <= '0;
    end else begin
      if (cmd_we) glb_en_q <= reg_wdata_i[CMD_EN_BIT];
      if (reg_we_i && (reg_addr_i == A_GLOBAL)) begin
        gmask_q[0] <= reg_wdata_i[1];
        gmask_q[1] <= reg_wdata_i[3];
      end
    end
  end

  assign src_w[0] = glb_en_q & net_any;
  assign src_w[1] = sf_irq_i;

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn
    assign opt_we_w[f]  = reg_we_i && (reg_addr_i == AW'(A_NET_OPT + 2*f));
    assign stat_we_w[f] = reg_we_i && (reg_addr_i == AW'(A_NET_STAT + 2*f));
    irq_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_w[f]),
      .opt_we_i  (opt_we_w[f]),
      .stat_we_i (stat_we_w[f]),
      .hide_i    (gmask_q[f]),
      .wdata_i   (reg_wdata_i),
      .opt_o     (opt_w[f]),
      .stat_o    (stat_w[f]),
      .pend_o    (pend_w[f]),
      .fire_o    (fire_w[f]),
      .route_o   (route_w[f]),
      .level_o   (level_w[f]),
      .en_o      (en_w[f]),
      .ack_o     (ack_w[f]),
      .req_o     (req_w[f])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CAUSE:    reg_rdata_o = cause_w;
      A_MASK:     reg_rdata_o = mask_w;
      A_GLOBAL:   reg_rdata_o = {4'b0, gmask_q[1], pend_w[1], gmask_q[0], pend_w[0]};
      A_NET_OPT:  reg_rdata_o = opt_w[0];
      A_NET_STAT: reg_rdata_o = stat_w[0];
      A_SF_OPT:   reg_rdata_o = opt_w[1];
      A_SF_STAT:  reg_rdata_o = stat_w[1];
      default:    reg_rdata_o = '0;
    endcase
  end

  assign int_n_o    = ~|(fire_w & ~route_w);
  assign stschg_n_o = ~|(fire_w & route_w);
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk
  import irq_merge_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    cause_w,
  input logic [NFUNC-1:0] fire_w,
  input logic [NFUNC-1:0] level_w,
  input logic [NFUNC-1:0] en_w,
  input logic [NFUNC-1:0] gmask_q,
  input logic [NFUNC-1:0] ack_w,
  input logic [NFUNC-1:0] req_w,
  input logic [NFUNC-1:0] stat_we_w
);
  a_r2_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_CAUSE) |=> ((cause_w & $past(cause_w)) == $past(cause_w)));

  a_r3_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CMD && reg_wdata_i[CMD_FORCE_BIT]) |=> cause_w[CAUSE_FORCE]);

  for (genvar f = 0; f < NFUNC; f++) begin : g_a
    a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_w[f] |=> !fire_w[f]);
    a_r5_hidden_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gmask_q[f] |=> !fire_w[f]);
    a_r8_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_w[f] && !level_w[f]) |=> (!fire_w[f] || level_w[f]));
    a_r10_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_w[f] && req_w[f] && !stat_we_w[f]) |=> req_w[f]);
  end
endmodule

bind irq_merge_top irq_merge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cause_w     (cause_w),
  .fire_w      (fire_w),
  .level_w     (level_w),
  .en_w        (en_w),
  .gmask_q     (gmask_q),
  .ack_w       (ack_w),
  .req_w       (req_w),
  .stat_we_w   (stat_we_w)
);

// File: tb/irq_merge_top_test.sv
module irq_merge_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] evt = '0;
  logic       sf_irq = 1'b0;
  logic       int_n, stschg_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_merge_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .net_evt_i(evt),
    .sf_irq_i(sf_irq), .int_n_o(int_n), .stschg_n_o(stschg_n)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  task automatic quiesce();
    wr(3'd1, 8'hFF); wr(3'd4, 8'h00); wr(3'd6, 8'h00);
    wr(3'd3, 8'h00); wr(3'd5, 8'h00); wr(3'd7, 8'h00);
    sf_irq = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 int pin", int_n, 1);
    check("R1 stschg pin", stschg_n, 1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg zero", d, 0);
    end
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    pulse_evt(8'h02);
    tick(3);
    rd(3'd1, d); check("R2 sticky", d, 8'h02);
    evt = 8'h02; wr(3'd1, 8'h02); evt = '0;
    rd(3'd1, d); check("R2 event wins clear", d, 8'h02);
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R2 clear", d, 8'h00);
    pulse_evt(8'h88);
    rd(3'd1, d); check("R2 ignored bits", d, 8'h00);
  endtask

  task automatic t_force();
    logic [7:0] d;
    wr(3'd0, 8'h0C);
    rd(3'd1, d); check("R3 force cause", d, 8'h80);
    wr(3'd1, 8'h80);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_level_mask();
    logic [7:0] d;
    wr(3'd4, 8'h44); wr(3'd2, 8'h20); wr(3'd0, 8'h04);
    pulse_evt(8'h20);
    check("R7 not yet", int_n, 1);
    tick();
    check("R7 still high", int_n, 1);
    rd(3'd3, d); check("R5 net pending", d, 8'h01);
    tick();
    check("R7 level low", int_n, 0);
    check("R9 other pin high", stschg_n, 1);
    tick(3);
    check("R7 held", int_n, 0);
    wr(3'd1, 8'h20);
    tick(2);
    check("R10 follows source", int_n, 1);
    wr(3'd2, 8'h00);
    pulse_evt(8'h01);
    tick(3);
    check("R4 masked", int_n, 1);
    wr(3'd2, 8'h01);
    tick(2);
    check("R4 unmasked", int_n, 0);
    wr(3'd0, 8'h00);
    tick(2);
    check("R4 global disable", int_n, 1);
    quiesce();
  endtask

  task automatic t_edge();
    int lows = 0;
    wr(3'd4, 8'h04); wr(3'd2, 8'hFF); wr(3'd0, 8'h04);
    pulse_evt(8'h02);
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!int_n) lows++;
    end
    check("R8 single pulse", lows, 1);
    wr(3'd1, 8'hFF);
    tick(3);
    lows = 0;
    pulse_evt(8'h10);
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!int_n) lows++;
    end
    check("R8 second pulse", lows, 1);
    quiesce();
  endtask

  task automatic t_route_hide();
    logic [7:0] d;
    wr(3'd4, 8'h64); wr(3'd2, 8'hFF); wr(3'd0, 8'h04);
    pulse_evt(8'h01);
    tick(2);
    check("R9 stschg low", stschg_n, 0);
    check("R9 int high", int_n, 1);
    wr(3'd3, 8'h02);
    tick();
    check("R5 hidden", stschg_n, 1);
    rd(3'd3, d); check("R5 global read", d, 8'h03);
    quiesce();
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(3'd4, 8'h44); wr(3'd5, 8'h01); wr(3'd2, 8'hFF); wr(3'd0, 8'h04);
    pulse_evt(8'h04);
    tick(2);
    check("R10 ack asserted", int_n, 0);
    wr(3'd1, 8'hFF);
    tick(3);
    check("R10 ack held", int_n, 0);
    rd(3'd5, d); check("R10 status", d, 8'h03);
    wr(3'd5, 8'h01);
    tick();
    check("R10 host clear", int_n, 1);
    rd(3'd5, d); check("R10 status cleared", d, 8'h01);
    quiesce();
  endtask

  task automatic t_second_fn();
    logic [7:0] d;
    wr(3'd6, 8'h00);
    sf_irq = 1'b1;
    tick(3);
    check("R6 disabled", int_n, 1);
    check("R6 disabled alt", stschg_n, 1);
    rd(3'd3, d); check("R6 not pending", d, 8'h00);
    wr(3'd6, 8'h44);
    tick();
    check("R11 sf asserts", int_n, 0);
    rd(3'd3, d); check("R5 sf pending", d, 8'h04);
    wr(3'd4, 8'h44); wr(3'd2, 8'hFF); wr(3'd0, 8'h04);
    pulse_evt(8'h01);
    tick(2);
    sf_irq = 1'b0;
    tick(3);
    check("R11 net keeps pin", int_n, 0);
    wr(3'd1, 8'hFF);
    tick(2);
    check("R11 both idle", int_n, 1);
    quiesce();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_force();
    t_level_mask();
    t_edge();
    t_route_hide();
    t_ack();
    t_second_fn();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule